// File: doc/BRIEF.md
# Core Debug Port Controller

This block sits between a host-side debug bus and a small processor core. The host issues single requests: a strobe, a write flag, a 16-bit address and 32-bit write data. The block answers each accepted request with a one-cycle acknowledge that carries the read data. It sorts the address into three regions. A request to the general-purpose register window goes to a register file port, and a request to the small debug window is served from the block's own control registers. Every other address goes to the control and status register port.

The block also decides when the core is halted. The host can hold the core with a stall input. The core stops by itself on a software breakpoint and, when single-step mode is enabled, after every retired instruction. An illegal instruction or an interrupt stops it only when the matching enable bit is set. A trap raises the breakpoint-hit output and records a cause code. The trap stays in place until the host writes a resume command or ends a stall.

Top module: `dbg_port_ctrl`

## Requirements
- R1: An address from 0x0800 to 0x081F raises `rf_req_o` in the cycle it is accepted. `rf_idx_o` carries address bits [4:0], and `rf_we_o` and `rf_wdata_o` copy the host request.
- R2: Addresses outside 0x0800–0x081F and outside 0x3000–0x3014 raise `csr_req_o` in the acceptance cycle with the full 16-bit address. Addresses inside the debug window reach neither port.
- R3: A strobe is accepted in any cycle where it is high and acknowledge is low. Acknowledge is high for exactly the next cycle. Read data is valid in that cycle, and a write returns zero.
- R4: The mode register at 0x3010 resets to 0. Bit 22 enables single-step, and every other bit reads 0 and ignores writes.
- R5: The event register at 0x3014 resets to 0. Bit 7 routes interrupts to the debugger and bit 6 routes illegal instructions. Every other bit reads 0 and ignores writes.
- R6: `core_halt_o` is high in every cycle where `dbg_stall_i` is high.
- R7: A breakpoint pulse while the core runs sets `dbg_bphit_o` and `core_halt_o` from the next cycle.
- R8: With single-step enabled, a retire pulse while the core runs traps in the same way.
- R9: An illegal-instruction pulse traps only when bit 6 is set, and an interrupt pulse traps only when bit 7 is set. With the bit clear the pulse has no effect.
- R10: `dbg_bphit_o` stays high until the host writes 0x3000 with bit 0 set, or until `dbg_stall_i` falls. Either one clears it from the next cycle.
- R11: A read of 0x3000 returns the current halt state in bit 0 and the cause in bits [3:1], where 0 means none, 1 breakpoint, 2 step, 3 illegal and 4 interrupt. When several events arrive together, the priority is breakpoint, then illegal, then interrupt, then step. A release clears the cause to 0.
- R12: Core events that arrive while the core is halted are ignored and leave the cause unchanged.
- R13: Other addresses inside 0x3000–0x3014 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_req_i | input | 1 | Host request strobe |
| dbg_we_i | input | 1 | Host write flag |
| dbg_addr_i | input | 16 | Host address |
| dbg_wdata_i | input | 32 | Host write data |
| dbg_rdata_o | output | 32 | Read data, valid with acknowledge |
| dbg_ack_o | output | 1 | One-cycle acknowledge |
| dbg_stall_i | input | 1 | Host halt request |
| dbg_bphit_o | output | 1 | Core trapped to the debugger |
| rf_req_o | output | 1 | Register file access |
| rf_we_o | output | 1 | Register file write |
| rf_idx_o | output | 5 | Register index |
| rf_wdata_o | output | 32 | Register write data |
| rf_rdata_i | input | 32 | Register read data, same cycle |
| csr_req_o | output | 1 | CSR access |
| csr_we_o | output | 1 | CSR write |
| csr_addr_o | output | 16 | CSR address |
| csr_wdata_o | output | 32 | CSR write data |
| csr_rdata_i | input | 32 | CSR read data, same cycle |
| core_ebreak_i | input | 1 | Breakpoint instruction executed |
| core_retire_i | input | 1 | Instruction retired |
| core_illegal_i | input | 1 | Illegal instruction seen |
| core_irq_i | input | 1 | Interrupt taken |
| core_halt_o | output | 1 | Halt the pipeline |

## Verification
Accesses are tried at both edges of each region (0x07FF, 0x0800, 0x081F, 0x0820, 0x2FFF, 0x3000, 0x3014, 0x3015). These show whether the window decode is off by one. Writes of all-ones to the debug registers expose any bit that is not masked. Each core event is applied with its enable clear and then set. Events are also stacked in the same cycle to tell the cause priority apart from simple arrival order. Events arrive while the core is already halted, and traps are released both by the resume write and by ending a stall.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_EBREAK  = 3'd1,
      CAUSE_STEP    = 3'd2,
      CAUSE_ILLEGAL = 3'd3,
      CAUSE_IRQ     = 3'd4
   } halt_cause_e;

   typedef enum logic [1:0] {
      RGN_CSR = 2'd0,
      RGN_GPR = 2'd1,
      RGN_DBG = 2'd2
   } region_e;

endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
   import dbg_port_pkg::*;
#(
   parameter int          AW       = 16,
   parameter int          GPR_N    = 32,
   parameter logic [AW-1:0] GPR_BASE = 16'h0800,
   parameter logic [AW-1:0] DBG_LO   = 16'h3000,
   parameter logic [AW-1:0] DBG_HI   = 16'h3014,
   localparam int         IDX_W    = $clog2(GPR_N)
) (
   input  logic [AW-1:0]    addr_i,
   output region_e          region_o,
   output logic [IDX_W-1:0] gpr_idx_o
);

   logic gpr_hit;
   logic dbg_hit;

   if (DBG_HI < DBG_LO) begin : g_bad_dbg_window
      $error("debug window upper bound below lower bound");
   end

   // Power-of-two windows decode by comparing upper bits; others by range.
   if ((1 << IDX_W) == GPR_N) begin : g_gpr_mask
      if ((GPR_BASE % GPR_N) != 0) begin : g_bad_align
         $error("register window base must be aligned to its size");
      end
      assign gpr_hit   = (addr_i[AW-1:IDX_W] == GPR_BASE[AW-1:IDX_W]);
      assign gpr_idx_o = addr_i[IDX_W-1:0];
   end else begin : g_gpr_range
      logic [AW-1:0] ofs;
      assign ofs       = addr_i - GPR_BASE;
      assign gpr_hit   = (addr_i >= GPR_BASE) && (ofs < AW'(GPR_N));
      assign gpr_idx_o = ofs[IDX_W-1:0];
   end

   assign dbg_hit = (addr_i >= DBG_LO) && (addr_i <= DBG_HI);

   always_comb begin
      if (gpr_hit)      region_o = RGN_GPR;
      else if (dbg_hit) region_o = RGN_DBG;
      else              region_o = RGN_CSR;
   end

endmodule

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
   import dbg_port_pkg::*;
#(
   parameter int            AW        = 16,
   parameter int            DW        = 32,
   parameter logic [AW-1:0] CTRL_ADDR = 16'h3000,
   parameter logic [AW-1:0] MODE_ADDR = 16'h3010,
   parameter logic [AW-1:0] EVT_ADDR  = 16'h3014,
   parameter int            STEP_BIT  = 22,
   parameter int            IRQ_BIT   = 7,
   parameter int            ILL_BIT   = 6
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_en_i,
   input  logic [AW-1:0] addr_i,
   input  logic          w_step_i,
   input  logic          w_irq_i,
   input  logic          w_ill_i,
   input  logic          w_go_i,
   input  logic          halted_i,
   input  halt_cause_e   cause_i,
   output logic          step_en_o,
   output logic          irq_en_o,
   output logic          ill_en_o,
   output logic          resume_o,
   output logic [DW-1:0] rdata_o
);

   if (DW <= STEP_BIT || DW <= IRQ_BIT || DW <= ILL_BIT || DW < 4) begin : g_bad_width
      $error("control bit position outside data width");
   end
   if (IRQ_BIT == ILL_BIT) begin : g_bad_bits
      $error("event enable bits must differ");
   end

   logic wr_mode, wr_evt;
   assign wr_mode  = wr_en_i && (addr_i == MODE_ADDR);
   assign wr_evt   = wr_en_i && (addr_i == EVT_ADDR);
   assign resume_o = wr_en_i && (addr_i == CTRL_ADDR) && w_go_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_en_o <= 1'b0;
         irq_en_o  <= 1'b0;
         ill_en_o  <= 1'b0;
      end else begin
         if (wr_mode) step_en_o <= w_step_i;
         if (wr_evt) begin
            irq_en_o <= w_irq_i;
            ill_en_o <= w_ill_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == CTRL_ADDR) begin
         rdata_o[0]   = halted_i;
         rdata_o[3:1] = cause_i;
      end else if (addr_i == MODE_ADDR) begin
         rdata_o[STEP_BIT] = step_en_o;
      end else if (addr_i == EVT_ADDR) begin
         rdata_o[IRQ_BIT] = irq_en_o;
         rdata_o[ILL_BIT] = ill_en_o;
      end
   end

   // R4: a mode write lands in the step enable on the next cycle
   a_r4_step_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mode |=> (step_en_o == $past(w_step_i)));
   // R5: an event write lands in both enables on the next cycle
   a_r5_evt_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_evt |=> (irq_en_o == $past(w_irq_i)) && (ill_en_o == $past(w_ill_i)));

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
   import dbg_port_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        stall_i,
   input  logic        ebreak_i,
   input  logic        retire_i,
   input  logic        illegal_i,
   input  logic        irq_i,
   input  logic        step_en_i,
   input  logic        irq_en_i,
   input  logic        ill_en_i,
   input  logic        resume_i,
   output logic        halt_o,
   output logic        trapped_o,
   output halt_cause_e cause_o
);

   logic        stall_q;
   logic        release_w;
   logic        fire;
   halt_cause_e new_cause;

   assign halt_o    = trapped_o || stall_i;
   assign release_w = resume_i || (stall_q && !stall_i);

   always_comb begin
      new_cause = CAUSE_NONE;
      if (ebreak_i)                    new_cause = CAUSE_EBREAK;
      else if (illegal_i && ill_en_i)  new_cause = CAUSE_ILLEGAL;
      else if (irq_i && irq_en_i)      new_cause = CAUSE_IRQ;
      else if (retire_i && step_en_i)  new_cause = CAUSE_STEP;
   end

   assign fire = !halt_o && (new_cause != CAUSE_NONE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stall_q   <= 1'b0;
         trapped_o <= 1'b0;
         cause_o   <= CAUSE_NONE;
      end else begin
         stall_q <= stall_i;
         if (fire) begin
            trapped_o <= 1'b1;
            cause_o   <= new_cause;
         end else if (release_w) begin
            trapped_o <= 1'b0;
            cause_o   <= CAUSE_NONE;
         end
      end
   end

   // R6: stall always holds the core
   a_r6_stall_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |-> halt_o);
   // R7: breakpoint while running traps with its cause
   a_r7_ebreak_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ebreak_i && !halt_o) |=> (trapped_o && cause_o == CAUSE_EBREAK));
   // R10: a resume while trapped clears the trap
   a_r10_resume_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resume_i && trapped_o) |=> !trapped_o);
   // R12: without a release a trap and its cause stay put
   a_r12_trap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trapped_o && !release_w) |=> (trapped_o && $stable(cause_o)));

endmodule

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
   import dbg_port_pkg::*;
#(
   parameter int            AW        = 16,
   parameter int            DW        = 32,
   parameter int            GPR_N     = 32,
   parameter logic [AW-1:0] GPR_BASE  = 16'h0800,
   parameter logic [AW-1:0] DBG_LO    = 16'h3000,
   parameter logic [AW-1:0] DBG_HI    = 16'h3014,
   parameter logic [AW-1:0] MODE_ADDR = 16'h3010,
   parameter logic [AW-1:0] EVT_ADDR  = 16'h3014,
   parameter int            STEP_BIT  = 22,
   parameter int            IRQ_BIT   = 7,
   parameter int            ILL_BIT   = 6,
   localparam int           IDX_W     = $clog2(GPR_N)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             dbg_req_i,
   input  logic             dbg_we_i,
   input  logic [AW-1:0]    dbg_addr_i,
   input  logic [DW-1:0]    dbg_wdata_i,
   output logic [DW-1:0]    dbg_rdata_o,
   output logic             dbg_ack_o,
   input  logic             dbg_stall_i,
   output logic             dbg_bphit_o,
   output logic             rf_req_o,
   output logic             rf_we_o,
   output logic [IDX_W-1:0] rf_idx_o,
   output logic [DW-1:0]    rf_wdata_o,
   input  logic [DW-1:0]    rf_rdata_i,
   output logic             csr_req_o,
   output logic             csr_we_o,
   output logic [AW-1:0]    csr_addr_o,
   output logic [DW-1:0]    csr_wdata_o,
   input  logic [DW-1:0]    csr_rdata_i,
   input  logic             core_ebreak_i,
   input  logic             core_retire_i,
   input  logic             core_illegal_i,
   input  logic             core_irq_i,
   output logic             core_halt_o
);

   region_e       region;
   logic          accept;
   logic          step_en, irq_en, ill_en, resume;
   logic          trapped;
   halt_cause_e   cause;
   logic [DW-1:0] dbg_rdata_int;
   logic [DW-1:0] rd_mux;

   assign accept = dbg_req_i && !dbg_ack_o;

   dbg_addr_decode #(
      .AW(AW), .GPR_N(GPR_N), .GPR_BASE(GPR_BASE), .DBG_LO(DBG_LO), .DBG_HI(DBG_HI)
   ) u_decode (
      .addr_i    (dbg_addr_i),
      .region_o  (region),
      .gpr_idx_o (rf_idx_o)
   );

   dbg_ctrl_regs #(
      .AW(AW), .DW(DW), .CTRL_ADDR(DBG_LO), .MODE_ADDR(MODE_ADDR), .EVT_ADDR(EVT_ADDR),
      .STEP_BIT(STEP_BIT), .IRQ_BIT(IRQ_BIT), .ILL_BIT(ILL_BIT)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (accept && dbg_we_i && region == RGN_DBG),
      .addr_i    (dbg_addr_i),
      .w_step_i  (dbg_wdata_i[STEP_BIT]),
      .w_irq_i   (dbg_wdata_i[IRQ_BIT]),
      .w_ill_i   (dbg_wdata_i[ILL_BIT]),
      .w_go_i    (dbg_wdata_i[0]),
      .halted_i  (core_halt_o),
      .cause_i   (cause),
      .step_en_o (step_en),
      .irq_en_o  (irq_en),
      .ill_en_o  (ill_en),
      .resume_o  (resume),
      .rdata_o   (dbg_rdata_int)
   );

   dbg_halt_ctrl u_halt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stall_i   (dbg_stall_i),
      .ebreak_i  (core_ebreak_i),
      .retire_i  (core_retire_i),
      .illegal_i (core_illegal_i),
      .irq_i     (core_irq_i),
      .step_en_i (step_en),
      .irq_en_i  (irq_en),
      .ill_en_i  (ill_en),
      .resume_i  (resume),
      .halt_o    (core_halt_o),
      .trapped_o (trapped),
      .cause_o   (cause)
   );

   assign dbg_bphit_o = trapped;

   assign rf_req_o    = accept && (region == RGN_GPR);
   assign rf_we_o     = rf_req_o && dbg_we_i;
   assign rf_wdata_o  = dbg_wdata_i;
   assign csr_req_o   = accept && (region == RGN_CSR);
   assign csr_we_o    = csr_req_o && dbg_we_i;
   assign csr_addr_o  = dbg_addr_i;
   assign csr_wdata_o = dbg_wdata_i;

   always_comb begin
      unique case (region)
         RGN_GPR: rd_mux = rf_rdata_i;
         RGN_DBG: rd_mux = dbg_rdata_int;
         default: rd_mux = csr_rdata_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dbg_ack_o   <= 1'b0;
         dbg_rdata_o <= '0;
      end else begin
         dbg_ack_o <= accept;
         if (accept) dbg_rdata_o <= dbg_we_i ? '0 : rd_mux;
      end
   end

   // R3: acknowledge lasts one cycle
   a_r3_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dbg_ack_o |=> !dbg_ack_o);
   // R3: an accepted strobe is acknowledged next cycle
   a_r3_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_req_i && !dbg_ack_o) |=> dbg_ack_o);
   // R1/R2: at most one downstream port per request
   a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rf_req_o, csr_req_o}));
   // R10: a trap is only ever flagged while the core is held
   a_r10_bphit_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dbg_bphit_o |-> core_halt_o);

endmodule

// File: tb/dbg_port_ctrl_bench.sv
module dbg_port_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 0, we = 0, stall = 0;
   logic [15:0] addr = 0;
   logic [31:0] wdata = 0;
   logic        eb = 0, rt = 0, il = 0, iq = 0;
   logic [31:0] rdata, rf_rdata, csr_rdata, csr_wdata, rf_wdata;
   logic        ack, bphit, rf_req, rf_we, csr_req, csr_we, halt;
   logic [4:0]  rf_idx;
   logic [15:0] csr_addr;

   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   assign rf_rdata  = {24'hA50000, 3'b000, rf_idx};
   assign csr_rdata = {16'hC0DE, csr_addr};

   dbg_port_ctrl u_dbg_port_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .dbg_req_i(req), .dbg_we_i(we), .dbg_addr_i(addr),
      .dbg_wdata_i(wdata), .dbg_rdata_o(rdata), .dbg_ack_o(ack), .dbg_stall_i(stall),
      .dbg_bphit_o(bphit), .rf_req_o(rf_req), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
      .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata), .csr_req_o(csr_req), .csr_we_o(csr_we),
      .csr_addr_o(csr_addr), .csr_wdata_o(csr_wdata), .csr_rdata_i(csr_rdata),
      .core_ebreak_i(eb), .core_retire_i(rt), .core_illegal_i(il), .core_irq_i(iq),
      .core_halt_o(halt)
   );

   // reference model state
   bit        m_ack, m_step, m_inte, m_iie, m_trap, m_stall_q;
   int        m_cause;
   bit [31:0] m_rdata;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit is_gpr(input logic [15:0] a);
      return a >= 16'h0800 && a <= 16'h081F;
   endfunction
   function automatic bit is_dbg(input logic [15:0] a);
      return a >= 16'h3000 && a <= 16'h3014;
   endfunction

   task automatic compare();
      bit acc, eg, ec;
      acc = req && !m_ack;
      eg  = acc && is_gpr(addr);
      ec  = acc && !is_gpr(addr) && !is_dbg(addr);
      chk(ack == m_ack, "R3 ack", ack, m_ack);
      if (m_ack) chk(rdata == m_rdata, "R3 rdata", rdata, m_rdata);
      chk(rf_req == eg, "R1 rf_req", rf_req, eg);
      if (eg) begin
         chk(rf_idx == addr[4:0], "R1 rf_idx", rf_idx, addr[4:0]);
         chk(rf_we == we && rf_wdata == wdata, "R1 rf_we/wdata", {rf_we, rf_wdata}, {we, wdata});
      end
      chk(csr_req == ec, "R2 csr_req", csr_req, ec);
      if (ec) chk(csr_addr == addr && csr_we == we && csr_wdata == wdata, "R2 csr fields",
                  {csr_we, csr_addr, csr_wdata}, {we, addr, wdata});
      chk(halt == (m_trap || stall), "R6 halt", halt, m_trap || stall);
      chk(bphit == m_trap, "R10 bphit", bphit, m_trap);
   endtask

   task automatic model_edge();
      bit acc, mh;
      int nc;
      acc = req && !m_ack;
      mh  = m_trap || stall;
      nc  = eb ? 1 : (il && m_iie) ? 3 : (iq && m_inte) ? 4 : (rt && m_step) ? 2 : 0;
      if (acc) begin
         if (we) m_rdata = 0;
         else if (is_gpr(addr)) m_rdata = {24'hA50000, 3'b000, addr[4:0]};
         else if (is_dbg(addr)) begin
            m_rdata = 0;
            if (addr == 16'h3000) m_rdata = {28'd0, 3'(m_cause), mh};
            if (addr == 16'h3010) m_rdata = 32'(m_step) << 22;
            if (addr == 16'h3014) m_rdata = (32'(m_inte) << 7) | (32'(m_iie) << 6);
         end else m_rdata = {16'hC0DE, addr};
      end
      if (!mh && nc != 0) begin
         m_trap = 1; m_cause = nc;
      end else if ((acc && we && addr == 16'h3000 && wdata[0]) || (m_stall_q && !stall)) begin
         m_trap = 0; m_cause = 0;
      end
      if (acc && we && addr == 16'h3010) m_step = wdata[22];
      if (acc && we && addr == 16'h3014) begin m_inte = wdata[7]; m_iie = wdata[6]; end
      m_stall_q = stall;
      m_ack = acc;
   endtask

   task automatic cyc();
      #1 compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic access(input bit w, input logic [15:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
      req = 1; we = w; addr = a; wdata = d;
      cyc();
      req = 0; we = 0;
      rd = rdata;
      cyc();
   endtask

   task automatic rd_exp(input logic [15:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] r;
      access(0, a, 0, r);
      chk(r == exp, tag, r, exp);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      logic [31:0] r;
      access(1, a, d, r);
   endtask

   task automatic event_pulse(input bit e, input bit r, input bit i, input bit q);
      eb = e; rt = r; il = i; iq = q;
      cyc();
      eb = 0; rt = 0; il = 0; iq = 0;
      cyc();
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      @(negedge clk); @(negedge clk);
      chk(ack == 0 && bphit == 0 && halt == 0, "R3 reset outputs", {ack, bphit, halt}, 0);
      rst_n = 1;
      cyc();
      // R4 R5 reset values
      rd_exp(16'h3010, 0, "R4 mode reset");
      rd_exp(16'h3014, 0, "R5 event reset");
      // R1 register window edges
      rd_exp(16'h0800, 32'hA5000000, "R1 gpr 0");
      rd_exp(16'h081F, 32'hA500001F, "R1 gpr 31");
      access(1, 16'h0805, 32'h1234_5678, r);
      chk(r == 0, "R3 write returns zero", r, 0);
      // R2 neighbours go to CSR
      rd_exp(16'h07FF, 32'hC0DE07FF, "R2 below gpr");
      rd_exp(16'h0820, 32'hC0DE0820, "R2 above gpr");
      rd_exp(16'h2FFF, 32'hC0DE2FFF, "R2 below dbg");
      rd_exp(16'h3015, 32'hC0DE3015, "R2 above dbg");
      wr(16'h0300, 32'hDEAD_BEEF);
      // R3 held strobe: accepted every other cycle
      req = 1; addr = 16'h0801;
      for (int k = 0; k < 4; k++) cyc();
      req = 0; cyc();
      // R4 R5 R13 masking
      wr(16'h3010, 32'hFFFF_FFFF);
      rd_exp(16'h3010, 32'h0040_0000, "R4 step bit only");
      wr(16'h3014, 32'hFFFF_FFFE);
      rd_exp(16'h3014, 32'h0000_00C0, "R5 enable bits only");
      wr(16'h3008, 32'hFFFF_FFFF);
      rd_exp(16'h3008, 0, "R13 hole reads zero");
      rd_exp(16'h3010, 32'h0040_0000, "R13 hole write ignored");
      wr(16'h3010, 0);
      wr(16'h3014, 0);
      // R9 disabled events have no effect
      event_pulse(0, 1, 1, 1);
      chk(bphit == 0 && halt == 0, "R9 disabled events ignored", {bphit, halt}, 0);
      // R6 stall
      stall = 1; cyc();
      rd_exp(16'h3000, 32'h1, "R6 stall halted no cause");
      stall = 0; cyc(); cyc();
      chk(bphit == 0 && halt == 0, "R10 stall only release", {bphit, halt}, 0);
      // R7 breakpoint, R12 ignore while halted, R10 resume
      event_pulse(1, 0, 0, 0);
      chk(bphit == 1, "R7 ebreak trap", bphit, 1);
      wr(16'h3014, 32'h0000_00C0);
      event_pulse(0, 0, 1, 1);
      rd_exp(16'h3000, 32'h3, "R12 cause kept while halted");
      wr(16'h3000, 1);
      chk(bphit == 0 && halt == 0, "R10 resume write", {bphit, halt}, 0);
      rd_exp(16'h3000, 32'h0, "R11 cause cleared");
      // R9 illegal and interrupt with enables set
      event_pulse(0, 0, 1, 0);
      rd_exp(16'h3000, 32'h7, "R9 illegal trap cause 3");
      wr(16'h3000, 1);
      event_pulse(0, 0, 0, 1);
      rd_exp(16'h3000, 32'h9, "R9 irq trap cause 4");
      wr(16'h3000, 1);
      // R8 single step
      wr(16'h3010, 32'h0040_0000);
      event_pulse(0, 1, 0, 0);
      rd_exp(16'h3000, 32'h5, "R8 step trap cause 2");
      wr(16'h3000, 1);
      // R11 priority
      event_pulse(1, 1, 1, 1);
      rd_exp(16'h3000, 32'h3, "R11 ebreak first");
      wr(16'h3000, 1);
      event_pulse(0, 1, 1, 1);
      rd_exp(16'h3000, 32'h7, "R11 illegal over irq");
      wr(16'h3000, 1);
      event_pulse(0, 1, 0, 1);
      rd_exp(16'h3000, 32'h9, "R11 irq over step");
      // R10 release by stall falling while trapped
      stall = 1; cyc(); cyc();
      chk(bphit == 1, "R10 trap held under stall", bphit, 1);
      stall = 0; cyc();
      chk(bphit == 0 && halt == 0, "R10 stall fall releases", {bphit, halt}, 0);
      // R12 events during stall are ignored
      stall = 1; cyc();
      event_pulse(1, 0, 0, 0);
      chk(bphit == 0, "R12 ebreak during stall", bphit, 0);
      stall = 0; cyc(); cyc();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule